// File: doc/BRIEF.md
# Pipeline Stage Boundary Skid Register

This block is a register slice placed between two pipeline stages. It carries a data word (an instruction) from the upstream stage to the downstream stage and passes backpressure the other way. The backpressure is registered: the stall the block shows upstream is the downstream stall taken through one flip-flop. Because of that one-cycle delay, the upstream stage can hand over one more word after the downstream stage has stopped. A single-entry side register catches that word. When the downstream stall clears, the output register reloads from the side register. Upstream sees the stall for one more cycle and then resumes.

A word of all zeros is a no-operation and never counts as data. Three parameters pick the implementation:
- The side register either loads only when a word arrives during a downstream stall, or loads on every cycle in which upstream is not stalled. Both choices give the same behaviour at the ports.
- Occupancy of the side register comes either from a stored flag or from testing the word for zero.
- An optional skip mode holds back the delayed stall while the side register holds only a no-operation. This removes the wasted cycle that occurs otherwise when the stall clears.

Handshake contract: the word on `up_data` is taken at a rising edge where `up_stall` is low. The word on `dn_data` is taken by the downstream stage at a rising edge where `dn_stall` is low.

Top module: `skid_boundary`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state, so that afterwards `dn_data` is all zeros and `up_stall` is low.
- R2: If `dn_stall` is high in a cycle, `dn_data` in the next cycle equals its current value.
- R3: With skip mode off, `up_stall` in every cycle equals the value `dn_stall` had in the previous cycle.
- R4: Upstream may present a word in a cycle where `dn_stall` is high and `up_stall` is low. That word is kept in the side register and later delivered.
- R5: In a cycle with `dn_stall` low and `up_stall` high, the next `dn_data` is the word held in the side register. That word is the last `up_data` accepted while `dn_stall` was high.
- R6: In a cycle with `dn_stall` low and `up_stall` low, the next `dn_data` equals the current `up_data`.
- R7: The side-register load policy (load only when needed, or load whenever not stalled) and the occupancy method (flag, or zero test) leave `up_stall` and `dn_data` unchanged, cycle for cycle.
- R8: With skip mode on, `up_stall` is high only if `dn_stall` was high in the previous cycle and the side register holds a non-zero word.
- R9: An all-zero word is a no-operation. A side register holding only zeros counts as empty.
- R10: Under any pattern of downstream stalls, every non-zero word accepted from upstream appears on `dn_data` and is taken by downstream exactly once, in acceptance order.
- R11: With skip mode on, suppose a stall ends and the side register caught only no-operations. Then the word upstream presents in the release cycle reaches `dn_data` in the next cycle. With skip mode off, a zero word appears there instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| up_data | input | WIDTH | Word from the upstream stage; zero is a no-operation |
| up_stall | output | 1 | Registered backpressure to the upstream stage |
| dn_data | output | WIDTH | Registered word to the downstream stage |
| dn_stall | input | 1 | Backpressure from the downstream stage |

## Verification
The hardest case to reach is a stall that starts and ends while the side register holds only no-operations, with a live word arriving exactly in the release cycle. Only there does skip mode differ from the plain delayed stall. A directed opening sequence produces it: a four-cycle stall fed with zero words, then a non-zero word aligned with the release. Several lanes with different parameters run side by side on the same stimulus. After that, random stall bursts and random zero and non-zero words run against each lane. A bench-side ordered scoreboard follows each lane to catch loss or duplication.

// File: rtl/skid_pkg.sv
package skid_pkg;

  // Policy for when the side register samples the upstream word.
  typedef enum logic {
    LOAD_ON_NEED,   // only when a word arrives while downstream is stalled
    LOAD_ALWAYS     // every cycle in which upstream is not stalled
  } buf_load_e;

  // How occupancy of the side register is determined.
  typedef enum logic {
    OCC_FLAG,       // separate stored flag
    OCC_NONZERO     // word itself tested against the all-zero no-op
  } occ_mode_e;

endpackage

// File: rtl/stall_delay.sv
module stall_delay (
  input  logic clk,
  input  logic rst,
  input  logic stall_in,
  output logic stall_q
);

  always_ff @(posedge clk) begin
    if (rst) stall_q <= 1'b0;
    else     stall_q <= stall_in;
  end

endmodule

// File: rtl/skid_buffer.sv
module skid_buffer
  import skid_pkg::*;
#(
  parameter int        WIDTH    = 32,
  parameter occ_mode_e OCC_MODE = OCC_FLAG
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] buf_q,
  output logic             occupied
);

  localparam logic [WIDTH-1:0] NOP_WORD = '0;

  always_ff @(posedge clk) begin
    if (rst)          buf_q <= NOP_WORD;
    else if (load_en) buf_q <= din;
  end

  generate
    if (OCC_MODE == OCC_FLAG) begin : g_flag
      logic full_q;
      always_ff @(posedge clk) begin
        if (rst)          full_q <= 1'b0;
        else if (load_en) full_q <= (din != NOP_WORD);
      end
      assign occupied = full_q;
    end else begin : g_zero_test
      assign occupied = (buf_q != NOP_WORD);
    end
  endgenerate

endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic             sel_held,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] held,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] next_word;

  assign next_word = sel_held ? held : live;

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (advance) q <= next_word;
  end

endmodule

// File: rtl/skid_boundary.sv
module skid_boundary
  import skid_pkg::*;
#(
  parameter int        WIDTH      = 32,
  parameter bit        SKIP_EMPTY = 1'b0,
  parameter buf_load_e LOAD_MODE  = LOAD_ON_NEED,
  parameter occ_mode_e OCC_MODE   = OCC_FLAG
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] up_data,
  output logic             up_stall,
  output logic [WIDTH-1:0] dn_data,
  input  logic             dn_stall
);

  logic             stall_q;
  logic             occupied;
  logic             hold_up;
  logic             load_en;
  logic [WIDTH-1:0] buf_q;

  stall_delay u_delay (
    .clk      (clk),
    .rst      (rst),
    .stall_in (dn_stall),
    .stall_q  (stall_q)
  );

  // Delayed stall, optionally masked while the side register is empty.
  assign hold_up  = stall_q && (occupied || !SKIP_EMPTY);
  assign up_stall = hold_up;

  generate
    if (LOAD_MODE == LOAD_ON_NEED) begin : g_load_need
      assign load_en = dn_stall && !hold_up;
    end else begin : g_load_always
      assign load_en = !hold_up;
    end
  endgenerate

  skid_buffer #(
    .WIDTH    (WIDTH),
    .OCC_MODE (OCC_MODE)
  ) u_buf (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .din      (up_data),
    .buf_q    (buf_q),
    .occupied (occupied)
  );

  out_stage #(
    .WIDTH (WIDTH)
  ) u_out (
    .clk      (clk),
    .rst      (rst),
    .advance  (!dn_stall),
    .sel_held (hold_up),
    .live     (up_data),
    .held     (buf_q),
    .q        (dn_data)
  );

endmodule

// File: rtl/skid_boundary_chk.sv
module skid_boundary_chk #(
  parameter int WIDTH      = 32,
  parameter bit SKIP_EMPTY = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] up_data,
  input logic             up_stall,
  input logic [WIDTH-1:0] dn_data,
  input logic             dn_stall,
  input logic [WIDTH-1:0] buf_q
);

  a_r2_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    dn_stall |=> $stable(dn_data));

  a_r6_pass_through: assert property (@(posedge clk) disable iff (rst)
    (!dn_stall && !up_stall) |=> (dn_data == $past(up_data)));

  a_r5_reload_from_side: assert property (@(posedge clk) disable iff (rst)
    (!dn_stall && up_stall) |=> (dn_data == $past(buf_q)));

  a_r8_stall_follows_down: assert property (@(posedge clk) disable iff (rst)
    up_stall |-> $past(dn_stall));

  generate
    if (!SKIP_EMPTY) begin : g_plain
      a_r3_one_cycle_delay: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (up_stall == $past(dn_stall)));
    end else begin : g_skip
      a_r8_stall_needs_word: assert property (@(posedge clk) disable iff (rst)
        up_stall |-> (buf_q != '0));
    end
  endgenerate

endmodule

bind skid_boundary skid_boundary_chk #(
  .WIDTH      (WIDTH),
  .SKIP_EMPTY (SKIP_EMPTY)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .up_data  (up_data),
  .up_stall (up_stall),
  .dn_data  (dn_data),
  .dn_stall (dn_stall),
  .buf_q    (buf_q)
);

// File: tb/skid_boundary_test.sv
module skid_boundary_test;
  import skid_pkg::*;

  localparam int N = 500;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dn_stall = 1'b0;
  logic [31:0] upd0 = '0, upd1 = '0;
  logic        ups0, ups1, ups2;
  logic [31:0] dnd0, dnd1, dnd2;

  logic [31:0] src [N];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  // lane 0: plain, load on need, flag occupancy
  skid_boundary uut (
    .clk(clk), .rst(rst), .up_data(upd0), .up_stall(ups0),
    .dn_data(dnd0), .dn_stall(dn_stall));

  // lane 1: skip mode, load always, zero-test occupancy
  skid_boundary #(.SKIP_EMPTY(1'b1), .LOAD_MODE(LOAD_ALWAYS), .OCC_MODE(OCC_NONZERO)) uut_skip (
    .clk(clk), .rst(rst), .up_data(upd1), .up_stall(ups1),
    .dn_data(dnd1), .dn_stall(dn_stall));

  // lane 2: plain, other load and occupancy variants, fed like lane 0
  skid_boundary #(.LOAD_MODE(LOAD_ALWAYS), .OCC_MODE(OCC_NONZERO)) uut_alt (
    .clk(clk), .rst(rst), .up_data(upd0), .up_stall(ups2),
    .dn_data(dnd2), .dn_stall(dn_stall));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int next_nz(input int from);
    int k = from;
    while (k < N && src[k] == 32'd0) k++;
    return k;
  endfunction

  task automatic deliver(input string lane, input logic [31:0] w, inout int ptr);
    int e;
    if (w != 32'd0) begin
      e = next_nz(ptr);
      if (e >= N) chk(1'b0, {"R10 extra word ", lane}, w, 32'd0);
      else begin
        chk(w == src[e], {"R4 R10 order ", lane}, w, src[e]);
        ptr = e + 1;
      end
    end
  endtask

  initial begin
    int idx0 = 0, idx1 = 0, ptr0 = 0, ptr1 = 0;
    int drain = 0, cyc = 0;
    logic ns;
    logic pv_ns = 1'b0, pv_s0 = 1'b0;
    logic [31:0] pv_upd0 = '0, pv_dnd0 = '0, caught0 = '0;
    logic s0, s1;
    logic [31:0] o0, o1;

    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin
      if ($urandom_range(0, 99) < 25) src[i] = 32'd0;
      else                            src[i] = $urandom | 32'd1;
    end
    for (int i = 0; i < 4; i++) src[i] = 32'd0;
    src[4] = 32'hC0DE_0005;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(dnd0 == 32'd0 && dnd1 == 32'd0 && dnd2 == 32'd0, "R1 dn_data", dnd0 | dnd1 | dnd2, 32'd0);
    chk(!ups0 && !ups1 && !ups2, "R1 up_stall", {29'd0, ups0, ups1, ups2}, 32'd0);
    rst = 1'b0;

    while ((idx0 < N || idx1 < N || drain < 12) && cyc < 20000) begin
      s0 = ups0; s1 = ups1; o0 = dnd0; o1 = dnd1;

      chk(s0 == pv_ns, "R3 delayed stall", {31'd0, s0}, {31'd0, pv_ns});
      chk(ups2 == s0 && dnd2 == o0, "R7 variant equivalence", dnd2, o0);
      if (s1) chk(pv_ns, "R8 stall without prior downstream stall", {31'd0, pv_ns}, 32'd1);
      if (cyc > 0) begin
        if (pv_ns)
          chk(o0 == pv_dnd0, "R2 hold", o0, pv_dnd0);
        else if (!pv_s0)
          chk(o0 == pv_upd0, "R6 pass-through", o0, pv_upd0);
        else
          chk(o0 == caught0, "R5 reload from side register", o0, caught0);
      end
      if (cyc == 2) begin
        chk(s0 == 1'b1, "R3 plain lane stalls", {31'd0, s0}, 32'd1);
        chk(s1 == 1'b0, "R8 R9 skip lane empty side register", {31'd0, s1}, 32'd0);
      end
      if (cyc == 5) begin
        chk(o1 == src[4], "R11 skip lane direct load", o1, src[4]);
        chk(o0 == 32'd0, "R11 plain lane bubble", o0, 32'd0);
      end

      if (idx0 >= N && idx1 >= N) begin
        ns = 1'b0;
        drain++;
      end else if (cyc < 4)  ns = 1'b1;
      else if (cyc < 10)     ns = 1'b0;
      else                   ns = ($urandom_range(0, 99) < 40);

      dn_stall = ns;
      upd0 = (idx0 < N) ? src[idx0] : 32'd0;
      upd1 = (idx1 < N) ? src[idx1] : 32'd0;

      if (!ns) begin
        deliver("lane0", o0, ptr0);
        deliver("lane1", o1, ptr1);
      end
      if (!s0 && ns) caught0 = upd0;
      if (!s0) idx0++;
      if (!s1) idx1++;

      pv_ns = ns; pv_s0 = s0; pv_upd0 = upd0; pv_dnd0 = o0;
      cyc++;
      @(negedge clk);
    end

    chk(next_nz(ptr0) == N, "R10 all words delivered lane0", ptr0, N);
    chk(next_nz(ptr1) == N, "R10 all words delivered lane1", ptr1, N);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule